// File: doc/BRIEF.md
# Software-Triggered ADC Channel Sequencer

This block is the digital controller that sits in front of a successive-approximation converter core. Software writes a small set of configuration registers over a simple write bus. A write that sets the enable bit starts one pass. In single-channel mode the pass converts the one channel that the channel register names. In sweep mode the pass converts channels 0, 1, ... up to the channel the same register names, in rising order. Each conversion is requested with a one-cycle start pulse that carries the channel index. The converter answers some cycles later with a done pulse and a 10-bit code. Each code is kept in the holding register of its own channel.

When the pass ends, a one-cycle interrupt pulse is raised and the busy flag drops. A configuration write while the block is enabled throws away the current pass and begins a new one under the new settings. This holds even when the write lands on the same cycle as the final done pulse. In that case the final code is still kept and the interrupt still fires before the new pass begins. Clearing the enable bit stops everything at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable flag, busy, the interrupt, conv_start, conv_abort, aux_cfg and every holding register read 0.
- R2: The bus decodes three addresses: 0 is the mode register, 1 is an auxiliary byte copied to aux_cfg, and 2 is the channel register, whose low log2(NCH) bits are used. In the mode register, bit 7 is enable and bit 4 selects sweep mode (1) or single-channel mode (0). Values 0xA0 and 0xB0 therefore start a single-channel pass and a sweep pass. A write to address 3 has no effect.
- R3: A single-channel pass issues exactly one start, for the channel that the channel register names. Its code goes to that channel's holding register.
- R4: A sweep pass issues starts for channels 0 up to the programmed last channel, in rising order. Each code goes to its own channel's holding register.
- R5: When the last done pulse of a pass arrives, irq is high for exactly one cycle. In that same cycle busy is already 0 and the final code is visible.
- R6: A write to any of the three configuration addresses while enabled ends the pass in progress. If a conversion is outstanding, conv_abort is high during the write cycle. In the next cycle a new pass starts from its first channel under the new settings.
- R7: A configuration write in the same cycle as the final done pulse still stores the final code and raises irq, and a new pass starts in the next cycle. A done pulse that coincides with a restart partway through a pass still stores its code.
- R8: Writing the mode register with bit 7 clear drops busy in the next cycle. A conversion result arriving after that is discarded and no interrupt is raised.
- R9: Writing the mode register with bit 7 set while already enabled, including when idle after a finished pass, starts a fresh pass.
- R10: While disabled, writes to addresses 1 and 2 only store their values and start no conversion. Holding registers keep their codes until a later conversion of the same channel overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| cfg_enable | output | 1 | Enable flag from the mode register |
| aux_cfg | output | 8 | Auxiliary configuration byte |
| busy | output | 1 | A pass is in progress |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | CW | Channel of the request |
| conv_abort | output | 1 | Outstanding conversion is to be dropped |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | RW | Converter result code |
| irq | output | 1 | End-of-pass interrupt pulse |
| results | output | NCH*RW | Holding registers, channel i at bits i*RW upward |

## Verification
The bench puts a configuration write on exactly the cycle of the final done pulse. A design that lets the write take priority would drop the code for channel 1 and stay silent, leaving the block enabled but idle with no result. The bench also checks a restart partway through a sweep. A design that did not cancel the outstanding request, or that resumed from the old channel, would show the wrong start order or stale codes. Aborting during a conversion and then delivering a late done pulse catches a design that stores orphaned results. Back-to-back enable writes while idle show whether re-enabling actually recovers a pass.

// File: rtl/adc_seq_pkg.sv
// Shared types and register decode constants for the ADC channel sequencer.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_AUX   = 2'd1;
    localparam logic [1:0] ADDR_CHSEL = 2'd2;

    localparam int MODE_EN_BIT   = 7;
    localparam int MODE_SWEEP_BIT = 4;
endpackage

// File: rtl/adc_seq_regs.sv
// Configuration registers and write decode.
// Produces restart/abort strobes in the write cycle, plus the values the
// registers will hold after that write. Assumes CW <= 8.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic          en,
    output logic          sweep,
    output logic [CW-1:0] chsel,
    output logic [7:0]    aux,
    output logic          restart,
    output logic          abort,
    output logic          nx_sweep,
    output logic [CW-1:0] nx_chsel
);
    logic mode_wr, aux_wr, sel_wr;
    logic wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // Decode which register this write addresses.
    assign mode_wr = bus_we && (bus_addr == ADDR_MODE);
    assign aux_wr  = bus_we && (bus_addr == ADDR_AUX);
    assign sel_wr  = bus_we && (bus_addr == ADDR_CHSEL);

    // Strobes: clearing enable aborts; enabling or reconfiguring while enabled restarts.
    assign abort   = mode_wr && !bus_wdata[MODE_EN_BIT];
    assign restart = (mode_wr && bus_wdata[MODE_EN_BIT]) || ((aux_wr || sel_wr) && en);

    // Settings in force after this cycle's write.
    assign nx_sweep = mode_wr ? bus_wdata[MODE_SWEEP_BIT] : sweep;
    assign nx_chsel = sel_wr  ? bus_wdata[CW-1:0]        : chsel;

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            sweep <= 1'b0;
            chsel <= '0;
            aux   <= '0;
        end else begin
            if (mode_wr) begin
                en    <= bus_wdata[MODE_EN_BIT];
                sweep <= bus_wdata[MODE_SWEEP_BIT];
            end
            if (sel_wr) chsel <= bus_wdata[CW-1:0];
            if (aux_wr) aux   <= bus_wdata;
        end
    end

    // R10: a write while disabled to aux or channel select never restarts.
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADDR_MODE && !en) |-> !restart);
endmodule

// File: rtl/adc_seq_fsm.sv
// Pass sequencer: issues conversion requests channel by channel, detects
// the final channel, and raises the end-of-pass pulse.
// Assumes the converter answers each start with one done pulse, and that it
// drops a request when conv_abort is raised.
// Abort wins over restart, and a restart wins over the normal next step.
// A done pulse in the restart cycle is still stored.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          abort,
    input  logic          nx_sweep,
    input  logic [CW-1:0] nx_chsel,
    input  logic          cfg_sweep,
    input  logic [CW-1:0] cfg_last,
    input  logic          conv_done,
    output logic          busy,
    output logic          conv_start,
    output logic [CW-1:0] conv_ch,
    output logic          conv_abort,
    output logic          store_en,
    output logic [CW-1:0] store_ch,
    output logic          irq
);
    seq_state_t    state_q;
    logic [CW-1:0] ch_q;
    logic [CW-1:0] first_ch;
    logic          is_final;

    // First channel of a pass that starts this cycle.
    assign first_ch = nx_sweep ? '0 : nx_chsel;
    // The current channel closes the pass.
    assign is_final = !cfg_sweep || (ch_q == cfg_last);

    // Outputs derived from the state.
    assign busy       = (state_q != SQ_IDLE);
    assign conv_start = (state_q == SQ_ISSUE);
    assign conv_ch    = ch_q;
    assign conv_abort = (abort || restart) && (state_q == SQ_WAIT);
    assign store_en   = (state_q == SQ_WAIT) && conv_done && !abort;
    assign store_ch   = ch_q;

    // State, channel pointer and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ch_q    <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= store_en && is_final;
            if (abort) begin
                state_q <= SQ_IDLE;
            end else if (restart) begin
                state_q <= SQ_ISSUE;
                ch_q    <= first_ch;
            end else begin
                case (state_q)
                    SQ_ISSUE: state_q <= SQ_WAIT;
                    SQ_WAIT: begin
                        if (conv_done) begin
                            if (is_final) begin
                                state_q <= SQ_IDLE;
                            end else begin
                                ch_q    <= ch_q + CW'(1);
                                state_q <= SQ_ISSUE;
                            end
                        end
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    // R5 / R7: the final done, even with a coincident write, yields the interrupt.
    p_final_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && conv_done && is_final && !abort) |=> irq);

    // R5: a pass that ends undisturbed leaves the block idle.
    p_idle_after_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && conv_done && is_final && !abort && !restart) |=> !busy);

    // R5: the interrupt is a single-cycle pulse.
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: clearing enable stops at once with no interrupt.
    p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !irq));

    // R6: a restart requests the first channel of the new pass.
    p_restart_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !abort) |=> (conv_start && conv_ch == $past(first_ch)));
endmodule

// File: rtl/adc_seq_results.sv
// Per-channel holding registers. A code is written only when the sequencer
// accepts a done pulse, and is held until that channel converts again.
module adc_seq_results #(
    parameter int NCH = 4,
    parameter int RW  = 10,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_idx,
    input  logic [RW-1:0]  wr_data,
    output logic [NCH*RW-1:0] results
);
    logic [RW-1:0] res_q [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Holding register for channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)                                res_q[i] <= '0;
            else if (wr_en && wr_idx == CW'(i))        res_q[i] <= wr_data;
        end
        assign results[i*RW +: RW] = res_q[i];

        // R10: an untouched channel keeps its code.
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == CW'(i)) |=> $stable(res_q[i]));
    end

    // R3 / R4: an accepted code lands in the addressed channel.
    p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (res_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the software-triggered ADC channel sequencer.
// Joins the register decode, the pass sequencer and the holding registers.
// Assumes NCH is a power of two between 2 and 256.
module adc_seq_ctrl #(
    parameter int NCH = 4,
    parameter int RW  = 10,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              cfg_enable,
    output logic [7:0]        aux_cfg,
    output logic              busy,
    output logic              conv_start,
    output logic [CW-1:0]     conv_ch,
    output logic              conv_abort,
    input  logic              conv_done,
    input  logic [RW-1:0]     conv_data,
    output logic              irq,
    output logic [NCH*RW-1:0] results
);
    logic          sweep, restart, abort, nx_sweep;
    logic [CW-1:0] chsel, nx_chsel, store_ch;
    logic          store_en;

    adc_seq_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .en       (cfg_enable),
        .sweep    (sweep),
        .chsel    (chsel),
        .aux      (aux_cfg),
        .restart  (restart),
        .abort    (abort),
        .nx_sweep (nx_sweep),
        .nx_chsel (nx_chsel)
    );

    adc_seq_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .abort     (abort),
        .nx_sweep  (nx_sweep),
        .nx_chsel  (nx_chsel),
        .cfg_sweep (sweep),
        .cfg_last  (chsel),
        .conv_done (conv_done),
        .busy      (busy),
        .conv_start(conv_start),
        .conv_ch   (conv_ch),
        .conv_abort(conv_abort),
        .store_en  (store_en),
        .store_ch  (store_ch),
        .irq       (irq)
    );

    adc_seq_results #(.NCH(NCH), .RW(RW)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_en),
        .wr_idx (store_ch),
        .wr_data(conv_data),
        .results(results)
    );
endmodule

// File: tb/adc_seq_ctrl_test.sv
// Self-checking bench: a vector table of passes, then directed corner cases.
module adc_seq_ctrl_test;
    localparam int NCH = 4;
    localparam int RW  = 10;
    localparam int CW  = 2;
    localparam int LAT = 5;
    localparam int NV  = 6;
    // Each vector: {sweep, channel, tag}.
    localparam logic [10:0] VECS [NV] = '{
        {1'b0, 2'd2, 8'd1},
        {1'b1, 2'd3, 8'd2},
        {1'b0, 2'd0, 8'd3},
        {1'b1, 2'd1, 8'd4},
        {1'b1, 2'd0, 8'd5},
        {1'b0, 2'd3, 8'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic cfg_enable, busy, conv_start, conv_abort, irq, conv_done;
    logic [CW-1:0] conv_ch;
    logic [7:0] aux_cfg;
    logic [RW-1:0] conv_data;
    logic [NCH*RW-1:0] results;

    logic auto_mode = 1'b1;
    logic man_done = 1'b0;
    logic [RW-1:0] man_data = '0;
    logic stub_done = 1'b0;
    logic [RW-1:0] stub_data = '0;
    logic [CW-1:0] stub_ch = '0;
    int stub_cnt = 0;
    int tag = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic [RW-1:0] exp_res [NCH];

    always #4 clk = ~clk;

    adc_seq_ctrl #(.NCH(NCH), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cfg_enable(cfg_enable), .aux_cfg(aux_cfg),
        .busy(busy), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_abort(conv_abort), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq), .results(results)
    );

    assign conv_done = auto_mode ? stub_done : man_done;
    assign conv_data = auto_mode ? stub_data : man_data;

    function automatic logic [RW-1:0] mk(input int t, input int ch);
        return RW'(t * 4 + ch);
    endfunction

    // Converter model: answers each start after LAT cycles, dropped on abort.
    always @(posedge clk) begin
        stub_done <= 1'b0;
        if (conv_start) begin
            stub_cnt <= LAT;
            stub_ch  <= conv_ch;
        end else if (conv_abort) begin
            stub_cnt <= 0;
        end else if (stub_cnt == 1) begin
            stub_done <= auto_mode;
            stub_data <= mk(tag, int'(stub_ch));
            stub_cnt  <= 0;
        end else if (stub_cnt > 1) begin
            stub_cnt <= stub_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [RW-1:0] res_of(input int ch);
        return results[ch*RW +: RW];
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_all_results(input string req);
        for (int c = 0; c < NCH; c++)
            chk(res_of(c) == exp_res[c], req, int'(res_of(c)), int'(exp_res[c]));
    endtask

    // Follow one pass from its first start; check order, count and interrupt.
    task automatic run_pass(input bit sw, input int sel, input string req);
        int n_start = 0;
        int n_irq = 0;
        int exp_n = sw ? sel + 1 : 1;
        bit order_ok = 1'b1;
        bit busy_ok = 1'b1;
        int cyc = 0;
        while (n_irq == 0 && cyc < 300) begin
            if (conv_start) begin
                if (int'(conv_ch) != (sw ? n_start : sel)) order_ok = 1'b0;
                n_start++;
            end
            if (irq) begin
                n_irq++;
                if (busy) busy_ok = 1'b0;
            end
            if (n_irq == 0) begin
                @(negedge clk);
                cyc++;
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (irq) n_irq++;
            if (conv_start) n_start++;
        end
        chk(order_ok, {req, " channel order"}, 0, 1);
        chk(n_start == exp_n, {req, " start count"}, n_start, exp_n);
        chk(n_irq == 1, "R5 single irq pulse", n_irq, 1);
        chk(busy_ok, "R5 busy low with irq", 1, 0);
        for (int c = 0; c < NCH; c++)
            if (sw ? (c <= sel) : (c == sel)) exp_res[c] = mk(tag, c);
        check_all_results({req, " holding registers"});
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) exp_res[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk(!cfg_enable && !busy && !irq && !conv_start && !conv_abort,
            "R1 control outputs", int'({cfg_enable, busy, irq, conv_start}), 0);
        chk(aux_cfg == 8'h00, "R1 aux", int'(aux_cfg), 0);
        check_all_results("R1 results");

        // R10 / R2: writes while disabled only store.
        begin
            bit quiet = 1'b1;
            bus_write(2'd1, 8'h5A);
            bus_write(2'd2, 8'h02);
            bus_write(2'd3, 8'hB0);
            for (int k = 0; k < 10; k++) begin
                if (busy || conv_start) quiet = 1'b0;
                @(negedge clk);
            end
            chk(aux_cfg == 8'h5A, "R2 aux register", int'(aux_cfg), 'h5A);
            chk(quiet && !cfg_enable, "R10 no conversion while disabled", int'(busy), 0);
        end

        // Vector table: R2, R3, R4, R5, R10.
        for (int v = 0; v < NV; v++) begin
            logic sw;
            logic [1:0] sel;
            sw  = VECS[v][10];
            sel = VECS[v][9:8];
            tag = int'(VECS[v][7:0]);
            bus_write(2'd0, sw ? 8'h30 : 8'h20);
            bus_write(2'd2, {6'd0, sel});
            bus_write(2'd0, sw ? 8'hB0 : 8'hA0);
            chk(busy && conv_start, "R2 enable write starts pass", int'(busy), 1);
            run_pass(sw, int'(sel), sw ? "R4 sweep" : "R3 single");
        end

        // R6: reconfigure partway through a sweep.
        begin
            int seen = 0;
            bus_write(2'd0, 8'h30);
            bus_write(2'd2, 8'h03);
            tag = 20;
            bus_write(2'd0, 8'hB0);
            while (seen < 2) begin
                if (conv_start) seen++;
                if (seen < 2) @(negedge clk);
            end
            @(negedge clk);
            exp_res[0] = mk(20, 0);
            tag = 21;
            bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
            #1;
            chk(conv_abort == 1'b1, "R6 outstanding request dropped", int'(conv_abort), 1);
            @(posedge clk);
            @(negedge clk);
            bus_we = 1'b0;
            chk(conv_start && conv_ch == 2'd0, "R6 restart from first channel", int'(conv_ch), 0);
            run_pass(1'b1, 1, "R6 restarted sweep");
        end

        // R7: write coincides with the final done.
        auto_mode = 1'b0;
        bus_write(2'd0, 8'h30);
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, 8'hB0);
        @(negedge clk);
        man_data = 10'h155; man_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        man_done = 1'b0;
        chk(conv_start && conv_ch == 2'd1, "R4 second channel issued", int'(conv_ch), 1);
        @(negedge clk);
        man_data = 10'h2AA; man_done = 1'b1;
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        @(posedge clk);
        @(negedge clk);
        man_done = 1'b0; bus_we = 1'b0;
        exp_res[0] = 10'h155;
        exp_res[1] = 10'h2AA;
        chk(irq == 1'b1, "R7 irq on collision", int'(irq), 1);
        chk(res_of(1) == 10'h2AA, "R7 final code stored", int'(res_of(1)), 'h2AA);
        chk(busy && conv_start && conv_ch == 2'd0, "R7 new pass begins", int'(busy), 1);
        @(negedge clk);
        chk(!irq, "R5 irq one cycle after collision", int'(irq), 0);

        // R8: abort, then a late done is discarded.
        begin
            bit no_irq = 1'b1;
            bus_write(2'd0, 8'h30);
            chk(!busy, "R8 busy drops on disable", int'(busy), 0);
            man_data = 10'h3FF; man_done = 1'b1;
            @(negedge clk);
            man_done = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (irq) no_irq = 1'b0;
                @(negedge clk);
            end
            chk(no_irq, "R8 no irq after abort", 1, 0);
            check_all_results("R8 late done discarded");
        end
        auto_mode = 1'b1;

        // R8: abort in the middle of an automatic conversion.
        begin
            bit no_irq = 1'b1;
            bus_write(2'd2, 8'h03);
            tag = 40;
            bus_write(2'd0, 8'hA0);
            @(negedge clk);
            bus_write(2'd0, 8'h20);
            chk(!busy, "R8 busy drops mid-conversion", int'(busy), 0);
            for (int k = 0; k < LAT + 6; k++) begin
                if (irq || conv_done) no_irq = 1'b0;
                @(negedge clk);
            end
            chk(no_irq, "R8 conversion cancelled", 1, 0);
            check_all_results("R8 channel 3 untouched");
        end

        // R9: re-enable while enabled and idle; R6 via aux write.
        bus_write(2'd2, 8'h01);
        tag = 50;
        bus_write(2'd0, 8'hA0);
        run_pass(1'b0, 1, "R3 single before re-enable");
        tag = 51;
        bus_write(2'd0, 8'hA0);
        chk(busy && conv_start, "R9 re-enable restarts", int'(busy), 1);
        run_pass(1'b0, 1, "R9 re-enabled pass");
        tag = 52;
        bus_write(2'd1, 8'h33);
        chk(busy && aux_cfg == 8'h33, "R6 aux write restarts", int'(busy), 1);
        run_pass(1'b0, 1, "R6 aux restart pass");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule